// File: doc/BRIEF.md
# Sparse Kernel Convolution Engine

This block evaluates one convolution layer while touching only the kernel weights that are not zero. The weights of every output channel are kept as a list of entries. Each entry holds a signed value, the input channel it reads, a vertical offset and a horizontal offset. A row of 16 processing lanes works on 16 adjacent output columns at the same time. For each list entry, one 16-value activation word is fetched from the source feature memory, and the entry's weight is multiplied into every lane. Zero weights are not in the list, so they cost no cycles.

Each lane accumulates its products over one output channel. When the channel's last entry has been applied, the sums go through a per-channel scale and bias, an arithmetic right shift, a ReLU and saturation. The resulting word is then written to the other feature memory. When a layer finishes, the two memories swap roles, so a second layer reads what the first one wrote. A host port reads and writes whichever memory is the current source.

Top module: `sparse_conv_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and the host port addresses bank 0 as the source memory.
- R2: For output row y, output channel oc and lane i, each weight entry (w, ch, dy, dx) of channel oc adds w × (lane i of the source word at address ((ch × inH) + (y + dy)) × 3 + dx). Activations are signed 8-bit values, and lane i occupies bits [8i+7:8i] of a word.
- R3: With acc the lane sum, the stored value is t = (acc × scale[oc] + bias[oc]) >>> 8, where the shift is arithmetic. It is written to address (oc × outH + y) × 3 of the destination memory, and this memory becomes readable through the host port once `done` has pulsed.
- R4: A `start` seen while idle runs the layer with `busy` high for exactly outH × E + 1 cycles, where E is the total number of weight entries over all output channels. `done` is then high for exactly one cycle, in the first cycle in which `busy` is low.
- R5: A negative t is stored as 0.
- R6: A t above 127 is stored as 127.
- R7: Each completed layer swaps the source and destination memories. A following layer therefore reads the previous layer's results, and after two layers the results sit in bank 0.
- R8: A `start` pulse while `busy` is high has no effect on the run length or the results.
- R9: The list of an output channel ends at the entry whose end flag is set. Channels are taken in order 0 to `cfgOutChM1`, and the list restarts from entry 0 for every output row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a layer when idle |
| cfgInH | input | 4 | Padded input feature height |
| cfgOutH | input | 4 | Number of output rows |
| cfgOutChM1 | input | 7 | Number of output channels minus one |
| wtWe | input | 1 | Weight list write enable |
| wtAddr | input | 6 | Weight list entry index |
| wtValue | input | 8 | Signed weight value |
| wtChan | input | 7 | Input channel of the entry |
| wtDy | input | 2 | Vertical kernel offset |
| wtDx | input | 2 | Horizontal kernel offset |
| wtLast | input | 1 | Entry closes its output channel |
| bnWe | input | 1 | Scale/bias table write enable |
| bnChan | input | 7 | Output channel of the scale/bias write |
| bnScale | input | 16 | Signed per-channel scale |
| bnBias | input | 32 | Signed per-channel bias |
| hostWe | input | 1 | Host write to source memory (ignored while busy) |
| hostAddr | input | 12 | Host word address |
| hostWdata | input | 128 | Host write word |
| hostRdata | output | 128 | Source memory word, one cycle after the address |
| busy | output | 1 | Layer in progress |
| done | output | 1 | One-cycle pulse at layer end |

## Verification
A wrong list pointer or end-flag decode puts a wrong sum into the very word written for that channel. It also changes the busy length, and the busy length is checked in the same layer. A bad address term (channel stride, row offset, column offset) corrupts only the lanes that read from the shifted location, so every output word is compared in full right after `done`. A bank-select fault shows up as stale data on the first host read after a layer. It also shows in the chained layer, which reads the previous results back in.

// File: rtl/sparse_conv_pkg.sv
package sparse_conv_pkg;
  localparam int PE        = 16;
  localparam int ACT_W     = 8;
  localparam int WT_W      = 8;
  localparam int ACC_W     = 24;
  localparam int SCALE_W   = 16;
  localparam int BIAS_W    = 32;
  localparam int BN_SHIFT  = 8;
  localparam int KW        = 3;
  localparam int KIDX_W    = 2;
  localparam int CH_W      = 7;
  localparam int H_W       = 4;
  localparam int MEM_DEPTH = 2304;
  localparam int ADDR_W    = $clog2(MEM_DEPTH);
  localparam int WST_DEPTH = 64;
  localparam int WST_AW    = $clog2(WST_DEPTH);
  localparam int WORD_W    = PE * ACT_W;
  localparam int NUM_CH    = 1 << CH_W;

  typedef struct packed {
    logic [WT_W-1:0]   value;
    logic [CH_W-1:0]   chan;
    logic [KIDX_W-1:0] dy;
    logic [KIDX_W-1:0] dx;
    logic              last;
  } wt_entry_t;

  typedef struct packed {
    logic              issue;
    logic              first;
    logic              last;
    logic [WT_W-1:0]   weight;
    logic [CH_W-1:0]   oc;
    logic [ADDR_W-1:0] rdAddr;
    logic [ADDR_W-1:0] wrAddr;
    logic              srcBank;
    logic              busy;
  } ctl_strobe_t;
endpackage

// File: rtl/sparse_conv_ctrl.sv
module sparse_conv_ctrl
  import sparse_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [H_W-1:0]    cfgInH,
  input  logic [H_W-1:0]    cfgOutH,
  input  logic [CH_W-1:0]   cfgOutChM1,
  input  logic              wtWe,
  input  logic [WST_AW-1:0] wtAddr,
  input  wt_entry_t         wtData,
  output ctl_strobe_t       stb,
  output logic              done
);
  typedef enum logic [1:0] {IDLE, RUN, DRAIN} state_t;

  state_t            state;
  logic [H_W-1:0]    yPos;
  logic [CH_W-1:0]   ocPos;
  logic [WST_AW-1:0] wp;
  logic              chanStart;
  logic              srcBank;
  wt_entry_t         wstore [WST_DEPTH];
  wt_entry_t         ent;

  function automatic logic [ADDR_W-1:0] fmAddr(
    input logic [CH_W-1:0] ch, input logic [H_W-1:0] hgt,
    input logic [H_W-1:0] row, input logic [KIDX_W-1:0] dy, input logic [KIDX_W-1:0] dx);
    logic [ADDR_W-1:0] t;
    t = ADDR_W'(ch) * ADDR_W'(hgt) + ADDR_W'(row) + ADDR_W'(dy);
    return t * ADDR_W'(KW) + ADDR_W'(dx);
  endfunction

  always_ff @(posedge clk) begin
    if (wtWe) wstore[wtAddr] <= wtData;
  end

  assign ent = wstore[wp];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      yPos      <= '0;
      ocPos     <= '0;
      wp        <= '0;
      chanStart <= 1'b1;
      srcBank   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state     <= RUN;
          yPos      <= '0;
          ocPos     <= '0;
          wp        <= '0;
          chanStart <= 1'b1;
        end
        RUN: begin
          if (ent.last) begin
            chanStart <= 1'b1;
            if (ocPos == cfgOutChM1) begin
              ocPos <= '0;
              wp    <= '0;
              if (yPos == cfgOutH - H_W'(1)) state <= DRAIN;
              else yPos <= yPos + H_W'(1);
            end else begin
              ocPos <= ocPos + CH_W'(1);
              wp    <= wp + WST_AW'(1);
            end
          end else begin
            chanStart <= 1'b0;
            wp        <= wp + WST_AW'(1);
          end
        end
        DRAIN: begin
          state   <= IDLE;
          done    <= 1'b1;
          srcBank <= ~srcBank;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    stb.issue   = (state == RUN);
    stb.first   = chanStart;
    stb.last    = ent.last;
    stb.weight  = ent.value;
    stb.oc      = ocPos;
    stb.rdAddr  = fmAddr(ent.chan, cfgInH, yPos, ent.dy, ent.dx);
    stb.wrAddr  = fmAddr(ocPos, cfgOutH, yPos, '0, '0);
    stb.srcBank = srcBank;
    stb.busy    = (state != IDLE);
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.busy) |-> $past(start));
  assert_done_swaps_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (srcBank != $past(srcBank)));
endmodule

// File: rtl/sparse_conv_datapath.sv
module sparse_conv_datapath
  import sparse_conv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctl_strobe_t               stb,
  input  logic                      bnWe,
  input  logic [CH_W-1:0]           bnChan,
  input  logic signed [SCALE_W-1:0] bnScale,
  input  logic signed [BIAS_W-1:0]  bnBias,
  input  logic                      hostWe,
  input  logic [ADDR_W-1:0]         hostAddr,
  input  logic [WORD_W-1:0]         hostWdata,
  output logic [WORD_W-1:0]         hostRdata
);
  localparam logic signed [63:0] ACT_MAX = 64'((1 << (ACT_W - 1)) - 1);

  logic signed [SCALE_W-1:0] scaleTab [NUM_CH];
  logic signed [BIAS_W-1:0]  biasTab  [NUM_CH];
  logic [WORD_W-1:0]         rdQ [2];
  logic [WORD_W-1:0]         rdWord;
  logic [WORD_W-1:0]         outVec;
  logic [ACT_W-1:0]          laneOut [PE];

  logic                      s1Valid, s1First, s1Last;
  logic signed [WT_W-1:0]    s1Weight;
  logic [CH_W-1:0]           s1Oc;
  logic [ADDR_W-1:0]         s1WrAddr;
  logic                      wrEn;
  logic signed [SCALE_W-1:0] curScale;
  logic signed [BIAS_W-1:0]  curBias;

  always_ff @(posedge clk) begin
    if (bnWe) begin
      scaleTab[bnChan] <= bnScale;
      biasTab[bnChan]  <= bnBias;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1First <= 1'b0;
      s1Last  <= 1'b0;
    end else begin
      s1Valid <= stb.issue;
      s1First <= stb.first;
      s1Last  <= stb.last;
    end
    s1Weight <= $signed(stb.weight);
    s1Oc     <= stb.oc;
    s1WrAddr <= stb.wrAddr;
  end

  assign wrEn     = s1Valid && s1Last;
  assign curScale = scaleTab[s1Oc];
  assign curBias  = biasTab[s1Oc];
  assign rdWord   = rdQ[stb.srcBank];
  assign hostRdata = rdWord;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [MEM_DEPTH];
    logic              isSrc, we;
    logic [ADDR_W-1:0] wa, ra;
    logic [WORD_W-1:0] wd;
    assign isSrc = (stb.srcBank == 1'(b));
    always_comb begin
      if (isSrc) begin
        we = hostWe && !stb.busy;
        wa = hostAddr;
        wd = hostWdata;
      end else begin
        we = wrEn;
        wa = s1WrAddr;
        wd = outVec;
      end
      ra = stb.busy ? stb.rdAddr : hostAddr;
    end
    always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rdQ[b] <= mem[ra];
    end
  end

  for (genvar i = 0; i < PE; i++) begin : g_lane
    logic signed [ACT_W-1:0]   act;
    logic signed [2*ACT_W-1:0] prod;
    logic signed [ACC_W-1:0]   acc, accNext;
    logic signed [63:0]        scaled, shifted;
    assign act     = $signed(rdWord[i*ACT_W +: ACT_W]);
    assign prod    = s1Weight * act;
    assign accNext = s1First ? ACC_W'(prod) : acc + ACC_W'(prod);
    assign scaled  = 64'(accNext) * 64'(curScale) + 64'(curBias);
    assign shifted = scaled >>> BN_SHIFT;
    always_comb begin
      if (shifted < 0)            laneOut[i] = '0;
      else if (shifted > ACT_MAX) laneOut[i] = ACT_MAX[ACT_W-1:0];
      else                        laneOut[i] = shifted[ACT_W-1:0];
    end
    always_ff @(posedge clk) begin
      if (!rstN) acc <= '0;
      else if (s1Valid) acc <= accNext;
    end
  end

  always_comb begin
    for (int k = 0; k < PE; k++) outVec[k*ACT_W +: ACT_W] = laneOut[k];
  end

  assert_write_while_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> stb.busy);
  assert_read_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue |-> (int'(stb.rdAddr) < MEM_DEPTH));
endmodule

// File: rtl/sparse_conv_engine.sv
module sparse_conv_engine
  import sparse_conv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [H_W-1:0]            cfgInH,
  input  logic [H_W-1:0]            cfgOutH,
  input  logic [CH_W-1:0]           cfgOutChM1,
  input  logic                      wtWe,
  input  logic [WST_AW-1:0]         wtAddr,
  input  logic [WT_W-1:0]           wtValue,
  input  logic [CH_W-1:0]           wtChan,
  input  logic [KIDX_W-1:0]         wtDy,
  input  logic [KIDX_W-1:0]         wtDx,
  input  logic                      wtLast,
  input  logic                      bnWe,
  input  logic [CH_W-1:0]           bnChan,
  input  logic signed [SCALE_W-1:0] bnScale,
  input  logic signed [BIAS_W-1:0]  bnBias,
  input  logic                      hostWe,
  input  logic [ADDR_W-1:0]         hostAddr,
  input  logic [WORD_W-1:0]         hostWdata,
  output logic [WORD_W-1:0]         hostRdata,
  output logic                      busy,
  output logic                      done
);
  ctl_strobe_t stb;
  wt_entry_t   wtData;

  assign wtData = '{value: wtValue, chan: wtChan, dy: wtDy, dx: wtDx, last: wtLast};
  assign busy   = stb.busy;

  sparse_conv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgInH(cfgInH), .cfgOutH(cfgOutH), .cfgOutChM1(cfgOutChM1),
    .wtWe(wtWe), .wtAddr(wtAddr), .wtData(wtData),
    .stb(stb), .done(done)
  );

  sparse_conv_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .bnWe(bnWe), .bnChan(bnChan), .bnScale(bnScale), .bnBias(bnBias),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );
endmodule

// File: tb/sparse_conv_engine_test.sv
module sparse_conv_engine_test;
  logic clk = 0, rstN = 0, start = 0;
  logic [3:0] cfgInH = 0, cfgOutH = 0;
  logic [6:0] cfgOutChM1 = 0;
  logic wtWe = 0, wtLast = 0, bnWe = 0, hostWe = 0;
  logic [5:0] wtAddr = 0;
  logic [7:0] wtValue = 0;
  logic [6:0] wtChan = 0, bnChan = 0;
  logic [1:0] wtDy = 0, wtDx = 0;
  logic signed [15:0] bnScale = 0;
  logic signed [31:0] bnBias = 0;
  logic [11:0] hostAddr = 0;
  logic [127:0] hostWdata = 0, hostRdata;
  logic busy, done;

  sparse_conv_engine uut (.*);

  always #4 clk = ~clk;

  int nTests = 0, nFail = 0;
  bit finished = 0;
  logic [127:0] bm [2][256];
  int srcM = 0;
  int wv [64], wc [64], wy [64], wx [64], wl [64];
  int nEnt;
  longint sc [8], bi [8];

  task automatic chk(bit ok, string req, logic [127:0] actV, logic [127:0] expV);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, actV, expV);
    end
  endtask

  function automatic logic [7:0] bnAct(longint acc, longint s, longint b);
    longint t = (acc * s + b) >>> 8;
    if (t < 0) return 8'd0;
    if (t > 127) return 8'd127;
    return t[7:0];
  endfunction

  task automatic hostWrite(int a, logic [127:0] d);
    @(negedge clk); hostWe = 1; hostAddr = 12'(a); hostWdata = d;
    @(negedge clk); hostWe = 0;
    bm[srcM][a] = d;
  endtask

  task automatic hostRead(int a, output logic [127:0] d);
    @(negedge clk); hostAddr = 12'(a);
    @(negedge clk); d = hostRdata;
  endtask

  task automatic fillSource(int words);
    for (int a = 0; a < words; a++) begin
      logic [127:0] d;
      for (int i = 0; i < 16; i++) d[i*8 +: 8] = 8'($urandom_range(0, 63) - 32);
      hostWrite(a, d);
    end
  endtask

  task automatic setBn(int ch, longint s, longint b);
    @(negedge clk); bnWe = 1; bnChan = 7'(ch); bnScale = 16'(s); bnBias = 32'(b);
    @(negedge clk); bnWe = 0;
    sc[ch] = s; bi[ch] = b;
  endtask

  task automatic genLayer(int outCh, int inCh, int maxDy, int maxDx);
    nEnt = 0;
    for (int oc = 0; oc < outCh; oc++) begin
      int k = $urandom_range(1, 4);
      for (int j = 0; j < k; j++) begin
        wv[nEnt] = $urandom_range(0, 31) - 16;
        wc[nEnt] = $urandom_range(0, inCh - 1);
        wy[nEnt] = $urandom_range(0, maxDy);
        wx[nEnt] = $urandom_range(0, maxDx);
        wl[nEnt] = (j == k - 1);
        nEnt++;
      end
    end
    for (int e = 0; e < nEnt; e++) begin
      @(negedge clk); wtWe = 1; wtAddr = 6'(e); wtValue = 8'(wv[e]);
      wtChan = 7'(wc[e]); wtDy = 2'(wy[e]); wtDx = 2'(wx[e]); wtLast = wl[e][0];
    end
    @(negedge clk); wtWe = 0;
  endtask

  task automatic modelLayer(int inH, int outH, int outCh);
    int dst = 1 - srcM;
    for (int y = 0; y < outH; y++) begin
      int ep = 0;
      for (int oc = 0; oc < outCh; oc++) begin
        longint acc [16];
        bit last;
        logic [127:0] w;
        for (int i = 0; i < 16; i++) acc[i] = 0;
        do begin
          int a = ((wc[ep] * inH) + (y + wy[ep])) * 3 + wx[ep];
          for (int i = 0; i < 16; i++)
            acc[i] += longint'(wv[ep]) * longint'($signed(bm[srcM][a][i*8 +: 8]));
          last = wl[ep][0];
          ep++;
        end while (!last);
        for (int i = 0; i < 16; i++) w[i*8 +: 8] = bnAct(acc[i], sc[oc], bi[oc]);
        bm[dst][(oc * outH + y) * 3] = w;
      end
    end
    srcM = dst;
  endtask

  task automatic runLayer(int inH, int outH, int outCh, bit midStart);
    int cnt = 0;
    @(negedge clk);
    cfgInH = 4'(inH); cfgOutH = 4'(outH); cfgOutChM1 = 7'(outCh - 1); start = 1;
    @(negedge clk); start = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      start = (midStart && cnt == 3);
      @(negedge clk);
    end
    start = 0;
    chk(cnt == outH * nEnt + 1, midStart ? "R8 busy length with extra start" : "R4 busy length",
        128'(cnt), 128'(outH * nEnt + 1));
    chk(done == 1'b1, "R4 done pulse", 128'(done), 128'd1);
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", 128'(done), 128'd0);
    modelLayer(inH, outH, outCh);
  endtask

  task automatic checkOutputs(int outH, int outCh, string req);
    for (int oc = 0; oc < outCh; oc++)
      for (int y = 0; y < outH; y++) begin
        logic [127:0] d;
        int a = (oc * outH + y) * 3;
        hostRead(a, d);
        chk(d === bm[srcM][a], req, d, bm[srcM][a]);
      end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 128'(busy), 128'd0);
    chk(done == 1'b0, "R1 done after reset", 128'(done), 128'd0);
    rstN = 1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after release", {busy, done}, 128'd0);

    // R2 R3 R8 R9: random layer with a start pulse during the run
    fillSource(2 * 6 * 3);
    for (int c = 0; c < 3; c++) setBn(c, $urandom_range(1, 8), longint'($urandom_range(0, 511)) - 256);
    genLayer(3, 2, 2, 2);
    runLayer(6, 4, 3, 1);
    checkOutputs(4, 3, "R2 R3 R9 layer output");

    // R7: chained layer reads previous results (dx = 0, dy <= 1)
    for (int c = 0; c < 2; c++) setBn(c, $urandom_range(1, 8), longint'($urandom_range(0, 255)) - 64);
    genLayer(2, 3, 1, 0);
    runLayer(4, 3, 2, 0);
    checkOutputs(3, 2, "R7 chained layer");
    chk(srcM == 0, "R7 results back in bank 0", 128'(srcM), 128'd0);

    // R5: large negative bias gives zero
    fillSource(2 * 5 * 3);
    for (int c = 0; c < 2; c++) setBn(c, 1, -1000000);
    genLayer(2, 2, 2, 2);
    runLayer(5, 3, 2, 0);
    for (int y = 0; y < 3; y++) begin
      logic [127:0] d;
      hostRead(y * 3, d);
      chk(d === 128'd0, "R5 relu to zero", d, 128'd0);
    end

    // R6: large positive result saturates to 127
    fillSource(2 * 5 * 3);
    for (int c = 0; c < 2; c++) setBn(c, 32767, 1 << 30);
    genLayer(2, 2, 2, 2);
    runLayer(5, 3, 2, 0);
    for (int y = 0; y < 3; y++) begin
      logic [127:0] d;
      hostRead((3 + y) * 3, d);
      chk(d === {16{8'h7f}}, "R6 saturation", d, {16{8'h7f}});
    end

    // R2 R3 R4 R9: randomized shapes
    for (int t = 0; t < 4; t++) begin
      int outH = $urandom_range(1, 5);
      int mdy = $urandom_range(0, 2);
      int inH = outH + mdy;
      int inCh = $urandom_range(1, 3);
      int outCh = $urandom_range(1, 4);
      fillSource(inCh * inH * 3);
      for (int c = 0; c < outCh; c++) setBn(c, $urandom_range(1, 8), longint'($urandom_range(0, 511)) - 256);
      genLayer(outCh, inCh, mdy, 2);
      runLayer(inH, outH, outCh, 0);
      checkOutputs(outH, outCh, "R2 R3 R9 random layer");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule